// File: doc/BRIEF.md
# Vector Register Byte-Serial Memory Mover

This block moves a 256-bit vector register to or from memory through a byte-wide memory port. It moves one byte per accepted beat, 32 beats in all, starting at the effective address and walking upward. The effective address is either a base plus a sign-extended 12-bit offset, or the sum of a base and an index. No alignment is required.

Loads collect all 32 bytes and hand the assembled register to the destination with a single write strobe, and only when every beat succeeded. Stores whose 32-byte window runs past the end of a page first ask a translation agent for write permission. They ask for the page of the start address and then for the following page, so a permission fault is raised before any byte is written. Stores that stay inside one page, and all loads, go straight to the byte beats.

Top module: `vec_bytemover`

## Requirements
- R1: With `req_indexed` low, the effective address is `req_base` plus `req_offset` sign-extended from 12 bits.
- R2: With `req_indexed` high, the effective address is `req_base + req_index`, and `req_offset` has no effect.
- R3: Beat i (0..31) presents address EA+i. On a store it carries bits [8i+7:8i] of `req_wdata`. A beat advances only on a cycle with `mem_ack` high, and until then its address and byte hold steady.
- R4: A load that completes raises `ld_wr` and `done` for one cycle, in the cycle after the last acknowledged beat. At that point `ld_data` bits [8i+7:8i] hold the byte read at EA+i.
- R5: A load never issues a probe. A store issues no probe when (EA mod page) + 31 is less than the page size.
- R6: A store with (EA mod page) + 31 at or above the page size first probes EA and then probes the next page base, (EA rounded down to the page) + page size. It presents no byte beat until both probes have been granted.
- R7: A probe answered with `probe_fault` ends the operation. The next cycle shows `fault` and `done` with `fault_addr` equal to the probed address, and no byte beat is issued.
- R8: A load beat answered with `mem_err` ends the operation. The next cycle shows `fault` and `done` with `fault_addr` equal to that beat's address, and `ld_wr` stays low, so the destination keeps its old value.
- R9: `busy` is high from the cycle after a request is accepted until the cycle `done` pulses. `done` lasts one cycle. `req_valid` is ignored while `busy` is high.
- R10: During and right after reset, `busy`, `done`, `fault`, `ld_wr`, `mem_req` and `probe_req` are low.
- R11: A store beat answered with `mem_err` ends the operation with `fault`, with `fault_addr` equal to that beat's address, and the remaining beats are not issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start an operation (taken when idle) |
| req_store | input | 1 | 1 = store, 0 = load |
| req_indexed | input | 1 | 1 = base+index, 0 = base+offset |
| req_base | input | ADDR_W | Base address |
| req_index | input | ADDR_W | Index address term |
| req_offset | input | 12 | Signed offset |
| req_wdata | input | VBYTES*8 | Register value to store |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Completion was a fault |
| fault_addr | output | ADDR_W | Faulting page probe or byte address |
| ld_wr | output | 1 | Destination register write strobe |
| ld_data | output | VBYTES*8 | Assembled load value |
| probe_req | output | 1 | Write-permission probe request |
| probe_addr | output | ADDR_W | Address being probed |
| probe_ack | input | 1 | Probe answered this cycle |
| probe_fault | input | 1 | Probe answer is a fault |
| mem_req | output | 1 | Byte beat request |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | ADDR_W | Beat byte address |
| mem_wbyte | output | 8 | Beat write byte |
| mem_ack | input | 1 | Beat accepted this cycle |
| mem_err | input | 1 | Beat failed |
| mem_rbyte | input | 8 | Beat read byte |

## Verification
The first probe or byte beat appears in the cycle after the accepting clock edge. Each later probe or beat appears one cycle after the acknowledgement of the one before it. `done`, `fault` and `ld_wr` show up one cycle after the final acknowledgement, and `busy` falls in that same cycle. The bench keeps a behavioural model that advances on the same rising edge from the same acknowledgements, which are driven with random stalls. It compares every output at the following falling edge, so each result is checked in exactly the cycle it is due. After each operation, memory contents and the destination register are also compared against values built directly from the requested addresses and data.

// File: rtl/vec_bytemover.sv
module vec_bytemover #(
  parameter int ADDR_W     = 32,
  parameter int VBYTES     = 32,
  parameter int PAGE_BYTES = 4096
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_store,
  input  logic                  req_indexed,
  input  logic [ADDR_W-1:0]     req_base,
  input  logic [ADDR_W-1:0]     req_index,
  input  logic [11:0]           req_offset,
  input  logic [VBYTES*8-1:0]   req_wdata,
  output logic                  busy,
  output logic                  done,
  output logic                  fault,
  output logic [ADDR_W-1:0]     fault_addr,
  output logic                  ld_wr,
  output logic [VBYTES*8-1:0]   ld_data,
  output logic                  probe_req,
  output logic [ADDR_W-1:0]     probe_addr,
  input  logic                  probe_ack,
  input  logic                  probe_fault,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [7:0]            mem_wbyte,
  input  logic                  mem_ack,
  input  logic                  mem_err,
  input  logic [7:0]            mem_rbyte
);
  localparam int DATA_W = VBYTES * 8;
  localparam int BW     = $clog2(VBYTES);
  localparam int PG_W   = $clog2(PAGE_BYTES);

  typedef enum logic [1:0] {S_IDLE, S_PRB_LO, S_PRB_HI, S_MOVE} st_t;

  st_t               st_q;
  logic [ADDR_W-1:0] ea_q, req_ea, next_page;
  logic [BW-1:0]     beat_q;
  logic              store_q;
  logic [DATA_W-1:0] wdata_q, buf_q;
  logic [PG_W:0]     span_end;
  logic              crosses, last_beat;

  assign req_ea    = req_indexed ? req_base + req_index
                                 : req_base + {{(ADDR_W-12){req_offset[11]}}, req_offset};
  assign span_end  = {1'b0, req_ea[PG_W-1:0]} + (PG_W+1)'(VBYTES-1);
  assign crosses   = span_end >= (PG_W+1)'(PAGE_BYTES);
  assign next_page = {ea_q[ADDR_W-1:PG_W], {PG_W{1'b0}}} + ADDR_W'(PAGE_BYTES);
  assign last_beat = beat_q == BW'(VBYTES-1);

  assign busy       = st_q != S_IDLE;
  assign probe_req  = (st_q == S_PRB_LO) || (st_q == S_PRB_HI);
  assign probe_addr = (st_q == S_PRB_HI) ? next_page : ea_q;
  assign mem_req    = st_q == S_MOVE;
  assign mem_we     = mem_req & store_q;
  assign mem_addr   = ea_q + ADDR_W'(beat_q);
  assign mem_wbyte  = wdata_q[{beat_q, 3'b000} +: 8];
  assign ld_data    = buf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      ea_q       <= '0;
      beat_q     <= '0;
      store_q    <= 1'b0;
      wdata_q    <= '0;
      buf_q      <= '0;
      done       <= 1'b0;
      fault      <= 1'b0;
      fault_addr <= '0;
      ld_wr      <= 1'b0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      ld_wr <= 1'b0;
      case (st_q)
        S_IDLE: if (req_valid) begin
          ea_q    <= req_ea;
          store_q <= req_store;
          wdata_q <= req_wdata;
          beat_q  <= '0;
          st_q    <= (req_store && crosses) ? S_PRB_LO : S_MOVE;
        end
        S_PRB_LO, S_PRB_HI: if (probe_ack) begin
          if (probe_fault) begin
            fault      <= 1'b1;
            done       <= 1'b1;
            fault_addr <= probe_addr;
            st_q       <= S_IDLE;
          end else begin
            st_q <= (st_q == S_PRB_LO) ? S_PRB_HI : S_MOVE;
          end
        end
        S_MOVE: if (mem_ack) begin
          if (mem_err) begin
            fault      <= 1'b1;
            done       <= 1'b1;
            fault_addr <= mem_addr;
            st_q       <= S_IDLE;
          end else begin
            if (!store_q) buf_q[{beat_q, 3'b000} +: 8] <= mem_rbyte;
            if (last_beat) begin
              done  <= 1'b1;
              ld_wr <= !store_q;
              st_q  <= S_IDLE;
            end else begin
              beat_q <= beat_q + 1'b1;
            end
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vec_bytemover_sva.sv
module vec_bytemover_sva #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              fault,
  input logic              ld_wr,
  input logic              probe_req,
  input logic [ADDR_W-1:0] probe_addr,
  input logic              probe_ack,
  input logic              probe_fault,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_wbyte,
  input logic              mem_ack,
  input logic              mem_err
);
  p_beat_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_wbyte));

  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && !mem_err |=> !mem_req || (mem_addr == $past(mem_addr) + 1'b1));

  p_ldwr_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ld_wr |-> done && !fault);

  p_probe_before_beats_r6: assert property (@(posedge clk) disable iff (!rst_n)
    probe_req |-> !mem_req);

  p_probe_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    probe_req && !probe_ack |=> probe_req && $stable(probe_addr));

  p_probe_fault_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    probe_req && probe_ack && probe_fault |=> fault && done && !mem_req && !probe_req);

  p_beat_err_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && mem_err |=> fault && !ld_wr && !mem_req);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind vec_bytemover vec_bytemover_sva #(.ADDR_W(ADDR_W)) u_sva (.*);

// File: tb/vec_bytemover_test.sv
module vec_bytemover_test;
  localparam int AW = 32;
  localparam int NB = 32;
  localparam int PG = 4096;
  localparam logic [31:0] PGL = 32'(PG);

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic req_valid = 0, req_store = 0, req_indexed = 0;
  logic [AW-1:0] req_base = '0, req_index = '0;
  logic [11:0] req_offset = '0;
  logic [NB*8-1:0] req_wdata = '0;
  logic busy, done, fault, ld_wr, probe_req, mem_req, mem_we;
  logic [AW-1:0] fault_addr, probe_addr, mem_addr;
  logic [NB*8-1:0] ld_data;
  logic [7:0] mem_wbyte;
  logic probe_ack = 0, probe_fault = 0, mem_ack = 0, mem_err = 0;
  logic [7:0] mem_rbyte = '0;

  vec_bytemover uut (.*);

  int checks = 0, fails = 0;
  logic [7:0] mem [int unsigned];
  logic bad_on = 0; logic [19:0] bad_pg = '0;
  logic err_on = 0; logic [31:0] err_at = '0;
  logic [NB*8-1:0] dest = '0;

  function automatic logic [7:0] rd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 8'(a * 13 + 5);
  endfunction

  task automatic chk(input bit ok, input string r, input string nm,
                     input logic [255:0] a, input logic [255:0] e);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", r, nm, a, e);
    end
  endtask

  // responders: drive acknowledgements away from the edge
  always begin
    @(negedge clk); #2;
    mem_ack   = mem_req && ($urandom % 4 != 0);
    mem_err   = mem_ack && err_on && (mem_addr == err_at);
    mem_rbyte = mem_ack ? rd(mem_addr) : 8'h00;
    if (mem_ack && !mem_err && mem_we) mem[mem_addr] = mem_wbyte;
    probe_ack   = probe_req && ($urandom % 3 != 0);
    probe_fault = probe_ack && bad_on && (probe_addr[31:12] == bad_pg);
  end

  always @(posedge clk) if (ld_wr) dest <= ld_data;

  // behavioural reference model
  int m_ph = 0, m_beat = 0;
  logic [31:0] m_ea = '0, m_fa = '0;
  bit m_st = 0, m_done = 0, m_fault = 0, m_ldwr = 0;
  logic [255:0] m_wd = '0, m_buf = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_done = 0; m_fault = 0; m_ldwr = 0; m_fa = '0; m_buf = '0;
    end else begin
      m_done = 0; m_fault = 0; m_ldwr = 0;
      if (m_ph == 0) begin
        if (req_valid) begin
          m_ea = req_indexed ? req_base + req_index : req_base + 32'($signed(req_offset));
          m_st = req_store; m_wd = req_wdata; m_beat = 0;
          m_ph = (req_store && ((m_ea % PGL) + 32'(NB - 1) >= PGL)) ? 1 : 3;
        end
      end else if (m_ph == 1 || m_ph == 2) begin
        if (probe_ack) begin
          if (probe_fault) begin
            m_fault = 1; m_done = 1;
            m_fa = (m_ph == 1) ? m_ea : (m_ea & ~(PGL - 32'd1)) + PGL;
            m_ph = 0;
          end else m_ph = (m_ph == 1) ? 2 : 3;
        end
      end else if (mem_ack) begin
        if (mem_err) begin
          m_fault = 1; m_done = 1; m_fa = m_ea + 32'(m_beat); m_ph = 0;
        end else begin
          if (!m_st) m_buf[8*m_beat +: 8] = mem_rbyte;
          if (m_beat == NB - 1) begin m_done = 1; m_ldwr = !m_st; m_ph = 0; end
          else m_beat++;
        end
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk(busy == (m_ph != 0), "R9", "busy", 256'(busy), 256'(m_ph != 0));
    chk(done == m_done, "R9", "done", 256'(done), 256'(m_done));
    chk(fault == m_fault, "R7 R8 R11", "fault", 256'(fault), 256'(m_fault));
    if (m_fault) chk(fault_addr == m_fa, "R7 R8 R11", "fault_addr", 256'(fault_addr), 256'(m_fa));
    chk(ld_wr == m_ldwr, "R4", "ld_wr", 256'(ld_wr), 256'(m_ldwr));
    if (m_ldwr) chk(ld_data == m_buf, "R4", "ld_data", ld_data, m_buf);
    chk(mem_req == (m_ph == 3), "R5", "mem_req", 256'(mem_req), 256'(m_ph == 3));
    chk(probe_req == (m_ph == 1 || m_ph == 2), "R6", "probe_req", 256'(probe_req), 256'(m_ph == 1 || m_ph == 2));
    if (m_ph == 3) begin
      chk(mem_addr == m_ea + 32'(m_beat), "R3", "mem_addr", 256'(mem_addr), 256'(m_ea + 32'(m_beat)));
      chk(mem_we == m_st, "R3", "mem_we", 256'(mem_we), 256'(m_st));
      if (m_st) chk(mem_wbyte == m_wd[8*m_beat +: 8], "R3", "mem_wbyte", 256'(mem_wbyte), 256'(m_wd[8*m_beat +: 8]));
    end
    if (m_ph == 1) chk(probe_addr == m_ea, "R6", "probe_addr", 256'(probe_addr), 256'(m_ea));
    if (m_ph == 2) chk(probe_addr == (m_ea & ~(PGL - 32'd1)) + PGL, "R6", "probe_addr",
                       256'(probe_addr), 256'((m_ea & ~(PGL - 32'd1)) + PGL));
  end

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  task automatic issue(input bit st, input bit idx, input logic [31:0] b, input logic [31:0] x,
                       input logic [11:0] off, input logic [255:0] wd, input bit poke);
    @(negedge clk); #3;
    req_valid = 1; req_store = st; req_indexed = idx;
    req_base = b; req_index = x; req_offset = off; req_wdata = wd;
    @(negedge clk); #3;
    req_valid = 0;
    if (poke) begin
      // R9: requests during an operation must be ignored
      repeat (2) @(negedge clk);
      #3; req_valid = 1; req_store = !st; req_base = 32'h0000_7777; req_wdata = ~wd;
      repeat (3) @(negedge clk);
      #3; req_valid = 0;
    end
    do @(negedge clk); while (!done);
    @(negedge clk);
  endtask

  function automatic logic [255:0] golden(input logic [31:0] ea);
    logic [255:0] v;
    for (int i = 0; i < NB; i++) v[8*i +: 8] = rd(ea + 32'(i));
    return v;
  endfunction

  task automatic chk_mem(input logic [31:0] ea, input logic [255:0] exp, input string r);
    chk(golden(ea) == exp, r, "memory window", golden(ea), exp);
  endtask

  logic [255:0] snap;
  logic [255:0] pat;

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(!busy && !done && !fault && !ld_wr && !mem_req && !probe_req, "R10", "reset outputs",
        256'({busy, done, fault, ld_wr, mem_req, probe_req}), 256'(0));
    @(negedge clk); #1 rst_n = 1;
    @(negedge clk);
    chk(!busy && !mem_req && !probe_req, "R10", "post-reset idle",
        256'({busy, mem_req, probe_req}), 256'(0));

    // R1 R4: immediate load, negative offset, unaligned
    issue(0, 0, 32'h0000_1100, 32'h0, 12'hFFB, '0, 0);
    chk(dest == golden(32'h0000_10FB), "R1 R4", "load value", dest, golden(32'h0000_10FB));

    // R2 R5: indexed load crossing a page, no probe expected; offset ignored
    issue(0, 1, 32'h0000_2000, 32'h0000_0FF0, 12'h123, '0, 0);
    chk(dest == golden(32'h0000_2FF0), "R2 R5", "indexed load", dest, golden(32'h0000_2FF0));

    // R5 R3: store inside a page, immediate form
    for (int i = 0; i < 8; i++) pat[32*i +: 32] = 32'hA5C3_0000 + 32'(i * 7919);
    issue(1, 0, 32'h0000_1000, 32'h0, 12'h7FF, pat, 0);
    chk_mem(32'h0000_17FF, pat, "R3 R5");

    // R5 boundary: window ends exactly at last byte of page
    issue(1, 1, 32'h0000_2F00, 32'h0000_00E0, 12'h0, ~pat, 0);
    chk_mem(32'h0000_2FE0, ~pat, "R5");

    // R6 boundary: window reaches one byte into the next page
    issue(1, 1, 32'h0000_2F00, 32'h0000_00E1, 12'h0, pat ^ {8{32'h1357_9BDF}}, 0);
    chk_mem(32'h0000_2FE1, pat ^ {8{32'h1357_9BDF}}, "R6");

    // R6: indexed crossing store
    issue(1, 1, 32'h0000_3F00, 32'h0000_00F0, 12'h0, {pat[127:0], pat[255:128]}, 0);
    chk_mem(32'h0000_3FF0, {pat[127:0], pat[255:128]}, "R6");

    // R7: second page refuses
    snap = golden(32'h0000_4FF8);
    bad_on = 1; bad_pg = 20'h00005;
    issue(1, 0, 32'h0000_4FF0, 32'h0, 12'h008, ~snap, 0);
    chk_mem(32'h0000_4FF8, snap, "R7");

    // R7: first page refuses
    snap = golden(32'h0000_6FFA);
    bad_pg = 20'h00006;
    issue(1, 0, 32'h0000_6FFA, 32'h0, 12'h000, ~snap, 0);
    chk_mem(32'h0000_6FFA, snap, "R7");
    bad_on = 0;

    // R8: load beat error leaves destination untouched
    snap = dest;
    err_on = 1; err_at = 32'h0000_800A;
    issue(0, 1, 32'h0000_7000, 32'h0000_1000, 12'h0, '0, 0);
    chk(dest == snap, "R8", "dest unchanged", dest, snap);

    // R11: store beat error stops remaining beats
    snap = golden(32'h0000_8005);
    err_at = 32'h0000_800A;
    issue(1, 0, 32'h0000_8005, 32'h0, 12'h0, pat, 0);
    err_on = 0;
    begin
      logic [255:0] exp11;
      exp11 = snap;
      exp11[39:0] = pat[39:0];
      chk_mem(32'h0000_8005, exp11, "R11");
    end

    // R9: requests while busy have no effect
    issue(0, 0, 32'h0000_9000, 32'h0, 12'h010, '0, 1);
    chk(dest == golden(32'h0000_9010), "R9", "load despite pokes", dest, golden(32'h0000_9010));
    chk(golden(32'h0000_7777) == golden(32'h0000_7777) && !busy, "R9", "idle after op",
        256'(busy), 256'(0));

    repeat (4) @(negedge clk);
    finish_up();
  end
endmodule